// File: doc/BRIEF.md
# Point-to-Point Trace Window Controller

This block sits between a bus event monitor and an on-chip trace memory. For every completed bus event (a data access, an instruction fetch or a taken branch) it decides whether a trace record should be written. When it decides yes, it issues a write strobe together with the event kind, address, data and a timestamp taken from a free-running counter of clock cycles.

Three recording policies are available. In window mode, a start-match pulse opens a recording window and an end-match pulse closes it; the window can be opened again any number of times. The window can optionally also be closed by a power-on reset indication, and it can be combined by AND with a per-access acquisition match. In halt mode, every event is recorded until a halt-match pulse arrives. The block then raises a sticky halted flag and stays silent until the host re-arms it. In condition mode, only data accesses whose acquisition match is true are recorded.

A branch record is not stamped when the branch completes. It waits for the next bus cycle and takes that cycle's stamp. If that following event is also recorded, its record comes out one cycle after the branch record and carries the same stamp.

Top module: `trace_window_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `rec_we_o` and `halted_o` are 0. The timestamp counter starts at 0 at release.
- R2: Window mode is `mode_i`=0. An event in the cycle of a start pulse is recorded, and so is an event in the cycle of an end pulse. Events between those two pulses are recorded. Events while the window is closed are not recorded.
- R3: After the window has closed, a new start pulse reopens it and recording resumes.
- R4: With `por_close_i`=1, a `por_evt_i` pulse closes the window, and an event in that same cycle is not recorded. With `por_close_i`=0, `por_evt_i` has no effect.
- R5: In window mode with `filt_en_i`=1, an event is recorded only when the window is open and `acq_hit_i` is 1. With `filt_en_i`=0, `acq_hit_i` is ignored.
- R6: Halt mode is `mode_i`=1. Every event is recorded until `halt_hit_i` is seen. The event in the halt cycle is not recorded. `halted_o` then stays 1 and no strobe is issued until a `rearm_i` pulse clears it one cycle later.
- R7: Condition mode is `mode_i`=2. Only data events (kind 0) with `acq_hit_i`=1 are recorded.
- R8: Each record appears one cycle after the event. Its stamp is the number of clock cycles since reset release that had passed at the event's edge. The counter is 48 bits wide and advances by one every cycle. Bus events are never presented in two consecutive cycles.
- R9: A recorded branch (kind 2) produces no strobe at first. The strobe for it comes one cycle after the next bus event and carries that event's stamp, whether or not that next event is recorded. A recorded non-branch event that releases a branch follows one cycle later with the same stamp.
- R10: The timestamp counter wraps from its maximum value to 0 without any indication.
- R11: Kind 3 marks an idle slot and is never recorded. `mode_i`=3 records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 2 | 0 window, 1 halt, 2 condition, 3 off |
| filt_en_i | input | 1 | AND the acquisition match into window mode |
| por_close_i | input | 1 | Let a power-on reset indication close the window |
| start_hit_i | input | 1 | Window start match pulse |
| end_hit_i | input | 1 | Window end match pulse |
| halt_hit_i | input | 1 | Halt match pulse (halt mode) |
| por_evt_i | input | 1 | Power-on reset indication pulse |
| rearm_i | input | 1 | Host re-arm pulse: clears window, halt and pending records |
| ev_valid_i | input | 1 | A bus event completes this cycle |
| ev_kind_i | input | 2 | 0 data, 1 fetch, 2 branch, 3 idle |
| ev_addr_i | input | 32 | Event address |
| ev_data_i | input | 32 | Event data |
| acq_hit_i | input | 1 | Per-access acquisition match |
| rec_we_o | output | 1 | Trace record write strobe |
| rec_kind_o | output | 2 | Record kind |
| rec_addr_o | output | 32 | Record address |
| rec_data_o | output | 32 | Record data |
| rec_ts_o | output | 48 | Record timestamp |
| halted_o | output | 1 | Sticky trace-halted flag |

## Verification
The hardest state to reach is a branch whose stamp is still outstanding while the window closes around it, or while the next event is itself a record. The stimulus first records a branch and follows it with a data access, to check the stamp sharing and the one-cycle order. It then records a branch in the cycle of an end pulse and follows it with a fetch outside the window, so only the deferred branch may come out. The 48-bit wrap cannot be reached in any reasonable run, so a second instance with a 5-bit counter is driven in parallel and its stamps are compared modulo 32.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  typedef enum logic [1:0] {
    KIND_DATA   = 2'd0,
    KIND_FETCH  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_NONE   = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    MODE_WINDOW = 2'd0,
    MODE_HALT   = 2'd1,
    MODE_COND   = 2'd2,
    MODE_OFF    = 2'd3
  } trc_mode_e;
endpackage

// File: rtl/tw_stamp.sv
`timescale 1ns/1ps
module tw_stamp #(
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] cnt_o
);
  localparam logic [TS_W-1:0] STEP = TS_W'(1);

  logic [TS_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + STEP;  // wraps silently

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tw_gate.sv
`timescale 1ns/1ps
module tw_gate
  import tw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       filt_en_i,
  input  logic       por_close_i,
  input  logic       start_hit_i,
  input  logic       end_hit_i,
  input  logic       halt_hit_i,
  input  logic       por_evt_i,
  input  logic       rearm_i,
  input  logic       evt_i,
  input  logic [1:0] kind_i,
  input  logic       acq_hit_i,
  output logic       take_o,
  output logic       flush_o,
  output logic       halted_o
);
  trc_mode_e mode;
  logic win_q, win_d, halted_q, halted_d;
  logic por_kill, win_eff, halt_set, policy_ok;

  always_comb begin
    mode     = trc_mode_e'(mode_i);
    por_kill = por_close_i & por_evt_i;
    win_eff  = (win_q | start_hit_i) & ~por_kill;
    halt_set = (mode == MODE_HALT) & halt_hit_i & ~halted_q;

    win_d    = rearm_i ? 1'b0 : ((win_q | start_hit_i) & ~end_hit_i & ~por_kill);
    halted_d = rearm_i ? 1'b0 : (halted_q | halt_set);

    unique case (mode)
      MODE_WINDOW: policy_ok = win_eff & (~filt_en_i | acq_hit_i);
      MODE_HALT:   policy_ok = 1'b1;
      MODE_COND:   policy_ok = acq_hit_i & (ev_kind_e'(kind_i) == KIND_DATA);
      default:     policy_ok = 1'b0;
    endcase

    flush_o = rearm_i | halted_q | halt_set;
    take_o  = evt_i & policy_ok & ~flush_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      win_q    <= win_d;
      halted_q <= halted_d;
    end
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/tw_record.sv
`timescale 1ns/1ps
module tw_record
  import tw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now_i,
  input  logic            evt_i,
  input  logic [1:0]      kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic            take_i,
  input  logic            flush_i,
  output logic            we_o,
  output logic [1:0]      kind_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic [TS_W-1:0] ts_o
);
  // branch awaiting its stamp
  logic            pv_q, pv_d;
  logic [AW-1:0]   pa_q, pa_d;
  logic [DW-1:0]   pd_q, pd_d;
  // stamped record waiting one cycle behind a released branch
  logic            hv_q, hv_d;
  logic [1:0]      hk_q, hk_d;
  logic [AW-1:0]   ha_q, ha_d;
  logic [DW-1:0]   hd_q, hd_d;
  logic [TS_W-1:0] ht_q, ht_d;
  // output register
  logic            we_q, we_d;
  logic [1:0]      ok_q, ok_d;
  logic [AW-1:0]   oa_q, oa_d;
  logic [DW-1:0]   od_q, od_d;
  logic [TS_W-1:0] ot_q, ot_d;

  logic is_br;

  always_comb begin
    is_br = (ev_kind_e'(kind_i) == KIND_BRANCH);
    pv_d = pv_q; pa_d = pa_q; pd_d = pd_q;
    hv_d = hv_q; hk_d = hk_q; ha_d = ha_q; hd_d = hd_q; ht_d = ht_q;
    we_d = 1'b0; ok_d = ok_q; oa_d = oa_q; od_d = od_q; ot_d = ot_q;

    if (flush_i) begin
      pv_d = 1'b0;
      hv_d = 1'b0;
    end else if (evt_i && pv_q) begin
      we_d = 1'b1; ok_d = KIND_BRANCH; oa_d = pa_q; od_d = pd_q; ot_d = now_i;
      pv_d = 1'b0;
      if (take_i) begin
        if (is_br) begin
          pv_d = 1'b1; pa_d = addr_i; pd_d = data_i;
        end else begin
          hv_d = 1'b1; hk_d = kind_i; ha_d = addr_i; hd_d = data_i; ht_d = now_i;
        end
      end
    end else if (hv_q) begin
      we_d = 1'b1; ok_d = hk_q; oa_d = ha_q; od_d = hd_q; ot_d = ht_q;
      hv_d = 1'b0;
    end else if (take_i) begin
      if (is_br) begin
        pv_d = 1'b1; pa_d = addr_i; pd_d = data_i;
      end else begin
        we_d = 1'b1; ok_d = kind_i; oa_d = addr_i; od_d = data_i; ot_d = now_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0; pa_q <= '0; pd_q <= '0;
      hv_q <= 1'b0; hk_q <= '0; ha_q <= '0; hd_q <= '0; ht_q <= '0;
      we_q <= 1'b0; ok_q <= '0; oa_q <= '0; od_q <= '0; ot_q <= '0;
    end else begin
      pv_q <= pv_d; pa_q <= pa_d; pd_q <= pd_d;
      hv_q <= hv_d; hk_q <= hk_d; ha_q <= ha_d; hd_q <= hd_d; ht_q <= ht_d;
      we_q <= we_d; ok_q <= ok_d; oa_q <= oa_d; od_q <= od_d; ot_q <= ot_d;
    end
  end

  assign we_o   = we_q;
  assign kind_o = ok_q;
  assign addr_o = oa_q;
  assign data_o = od_q;
  assign ts_o   = ot_q;
endmodule

// File: rtl/trace_window_ctrl.sv
`timescale 1ns/1ps
module trace_window_ctrl
  import tw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            filt_en_i,
  input  logic            por_close_i,
  input  logic            start_hit_i,
  input  logic            end_hit_i,
  input  logic            halt_hit_i,
  input  logic            por_evt_i,
  input  logic            rearm_i,
  input  logic            ev_valid_i,
  input  logic [1:0]      ev_kind_i,
  input  logic [AW-1:0]   ev_addr_i,
  input  logic [DW-1:0]   ev_data_i,
  input  logic            acq_hit_i,
  output logic            rec_we_o,
  output logic [1:0]      rec_kind_o,
  output logic [AW-1:0]   rec_addr_o,
  output logic [DW-1:0]   rec_data_o,
  output logic [TS_W-1:0] rec_ts_o,
  output logic            halted_o
);
  logic [TS_W-1:0] ts_now;
  logic evt, take, flush;

  // an idle-kind slot does not complete a bus cycle
  assign evt = ev_valid_i & (ev_kind_e'(ev_kind_i) != KIND_NONE);

  tw_stamp #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .cnt_o(ts_now)
  );

  tw_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .filt_en_i(filt_en_i),
    .por_close_i(por_close_i), .start_hit_i(start_hit_i), .end_hit_i(end_hit_i),
    .halt_hit_i(halt_hit_i), .por_evt_i(por_evt_i), .rearm_i(rearm_i),
    .evt_i(evt), .kind_i(ev_kind_i), .acq_hit_i(acq_hit_i),
    .take_o(take), .flush_o(flush), .halted_o(halted_o)
  );

  tw_record #(.AW(AW), .DW(DW), .TS_W(TS_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .now_i(ts_now), .evt_i(evt), .kind_i(ev_kind_i),
    .addr_i(ev_addr_i), .data_i(ev_data_i), .take_i(take), .flush_i(flush),
    .we_o(rec_we_o), .kind_o(rec_kind_o), .addr_o(rec_addr_o),
    .data_o(rec_data_o), .ts_o(rec_ts_o)
  );
endmodule

// File: rtl/tw_checker.sv
`timescale 1ns/1ps
module tw_checker #(
  parameter int TS_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rearm_i,
  input logic            ev_valid_i,
  input logic            rec_we_o,
  input logic            halted_o,
  input logic [TS_W-1:0] ts_now
);
  assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !rec_we_o);

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !rearm_i) |=> halted_o);

  assert_rearm_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (!halted_o && !rec_we_o));

  assert_ts_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_now == TS_W'($past(ts_now) + TS_W'(1)));

  assert_ev_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i |=> !ev_valid_i);

  assert_ts_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_now == {TS_W{1'b1}}) |=> ts_now == '0);
endmodule

bind trace_window_ctrl tw_checker #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rearm_i(rearm_i), .ev_valid_i(ev_valid_i),
  .rec_we_o(rec_we_o), .halted_o(halted_o), .ts_now(ts_now)
);

// File: tb/sim_trace_window_ctrl.sv
`timescale 1ns/1ps
module sim_trace_window_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic filt_en, por_cl, start_h, end_h, halt_h, por, rearm, ev_valid, acq;
  logic [1:0] ev_kind;
  logic [31:0] ev_addr, ev_data;

  logic        rec_we, halted;
  logic [1:0]  rec_kind;
  logic [31:0] rec_addr, rec_data;
  logic [47:0] rec_ts;

  logic        s_we, s_halted;
  logic [1:0]  s_kind;
  logic [31:0] s_addr, s_data;
  logic [4:0]  s_ts;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] tcnt;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= 64'd0;
    else        tcnt <= tcnt + 64'd1;

  trace_window_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .filt_en_i(filt_en), .por_close_i(por_cl),
    .start_hit_i(start_h), .end_hit_i(end_h), .halt_hit_i(halt_h), .por_evt_i(por),
    .rearm_i(rearm), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind), .ev_addr_i(ev_addr),
    .ev_data_i(ev_data), .acq_hit_i(acq), .rec_we_o(rec_we), .rec_kind_o(rec_kind),
    .rec_addr_o(rec_addr), .rec_data_o(rec_data), .rec_ts_o(rec_ts), .halted_o(halted)
  );

  trace_window_ctrl #(.TS_W(5)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .filt_en_i(filt_en), .por_close_i(por_cl),
    .start_hit_i(start_h), .end_hit_i(end_h), .halt_hit_i(halt_h), .por_evt_i(por),
    .rearm_i(rearm), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind), .ev_addr_i(ev_addr),
    .ev_data_i(ev_data), .acq_hit_i(acq), .rec_we_o(s_we), .rec_kind_o(s_kind),
    .rec_addr_o(s_addr), .rec_data_o(s_data), .rec_ts_o(s_ts), .halted_o(s_halted)
  );

  // row: [11:10] tag(0 R2,1 R3,2 R5,3 R7) [9:8] mode [7] filt [6] start [5] end
  //      [4] valid [3:2] kind [1] acq [0] expected strobe
  function automatic logic [11:0] rw(int t, int m, int f, int s, int e, int v, int k, int a, int x);
    return {t[1:0], m[1:0], f[0], s[0], e[0], v[0], k[1:0], a[0], x[0]};
  endfunction

  localparam int NV = 30;
  localparam logic [11:0] VEC [NV] = '{
    rw(0,0,0,0,0,1,0,0,0), rw(0,0,0,0,0,0,0,0,0),
    rw(0,0,0,1,0,1,1,0,1), rw(0,0,0,0,0,0,0,0,0),
    rw(0,0,0,0,0,1,0,0,1), rw(0,0,0,0,0,0,0,0,0),
    rw(0,0,0,0,1,1,0,0,1), rw(0,0,0,0,0,0,0,0,0),
    rw(0,0,0,0,0,1,1,0,0), rw(0,0,0,0,0,0,0,0,0),
    rw(1,0,0,1,0,0,0,0,0), rw(1,0,0,0,0,1,0,0,1),
    rw(1,0,0,0,0,0,0,0,0), rw(2,0,1,0,0,1,0,0,0),
    rw(2,0,1,0,0,0,0,0,0), rw(2,0,1,0,0,1,1,1,1),
    rw(2,0,1,0,1,0,0,0,0), rw(2,0,1,0,0,1,0,1,0),
    rw(2,0,1,0,0,0,0,0,0), rw(3,2,0,0,0,1,0,1,1),
    rw(3,2,0,0,0,0,0,0,0), rw(3,2,0,0,0,1,1,1,0),
    rw(3,2,0,0,0,0,0,0,0), rw(3,2,0,0,0,1,0,0,0),
    rw(3,2,0,0,0,0,0,0,0), rw(0,0,0,1,1,1,0,0,1),
    rw(0,0,0,0,0,0,0,0,0), rw(0,0,0,0,0,1,0,0,0),
    rw(0,0,0,0,0,0,0,0,0), rw(3,2,0,0,0,1,3,1,0)
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    start_h = 0; end_h = 0; halt_h = 0; por = 0; rearm = 0; ev_valid = 0;
  endtask

  task automatic ev(input logic [1:0] k, input logic [31:0] a, input logic q);
    ev_valid = 1; ev_kind = k; ev_addr = a; ev_data = ~a; acq = q;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] tsv;
    string tg;
    rst_n = 0; mode = 0; filt_en = 0; por_cl = 0; start_h = 0; end_h = 0; halt_h = 0;
    por = 0; rearm = 0; ev_valid = 0; acq = 0; ev_kind = 0; ev_addr = 0; ev_data = 0;
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", {63'd0, rec_we}, 64'd0);
    chk("R1 halted in reset", {63'd0, halted}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 strobe after release", {63'd0, rec_we}, 64'd0);
    chk("R1 halted after release", {63'd0, halted}, 64'd0);

    // table walk: window, reopen, filter, condition mode
    for (int i = 0; i < NV; i++) begin
      logic [11:0] r;
      r = VEC[i];
      case (r[11:10])
        2'd0: tg = "R2";
        2'd1: tg = "R3";
        2'd2: tg = "R5";
        default: tg = "R7";
      endcase
      mode = r[9:8]; filt_en = r[7]; start_h = r[6]; end_h = r[5];
      if (r[4]) ev(r[3:2], 32'h100 + 32'(i), r[1]);
      cyc();
      chk($sformatf("%s row %0d strobe", tg, i), {63'd0, rec_we}, {63'd0, r[0]});
      if (r[0]) begin
        chk($sformatf("%s row %0d kind", tg, i), {62'd0, rec_kind}, {62'd0, r[3:2]});
        chk($sformatf("R8 row %0d stamp", i), {16'd0, rec_ts}, tcnt - 64'd1);
      end
    end

    // R4: power-on reset closing
    mode = 0; filt_en = 0; por_cl = 0;
    rearm = 1; cyc();
    start_h = 1; cyc();
    por = 1; ev(0, 32'h200, 0); cyc();
    chk("R4 por ignored when disabled", {63'd0, rec_we}, 64'd1);
    cyc();
    por_cl = 1; por = 1; ev(0, 32'h204, 0); cyc();
    chk("R4 por closes same cycle", {63'd0, rec_we}, 64'd0);
    cyc();
    ev(0, 32'h208, 0); cyc();
    chk("R4 window stays closed", {63'd0, rec_we}, 64'd0);
    cyc();
    por_cl = 0;

    // R9: deferred branch stamp
    rearm = 1; cyc();
    start_h = 1; ev(2, 32'h300, 0); cyc();
    chk("R9 branch not yet written", {63'd0, rec_we}, 64'd0);
    cyc();
    ev(0, 32'h304, 0); cyc();
    tsv = tcnt - 64'd1;
    chk("R9 branch strobe", {63'd0, rec_we}, 64'd1);
    chk("R9 branch kind", {62'd0, rec_kind}, 64'd2);
    chk("R9 branch addr", {32'd0, rec_addr}, 64'h300);
    chk("R9 branch stamp", {16'd0, rec_ts}, tsv);
    cyc();
    chk("R9 follower strobe", {63'd0, rec_we}, 64'd1);
    chk("R9 follower addr", {32'd0, rec_addr}, 64'h304);
    chk("R9 follower shares stamp", {16'd0, rec_ts}, tsv);
    cyc();
    chk("R9 quiet after pair", {63'd0, rec_we}, 64'd0);
    end_h = 1; ev(2, 32'h310, 0); cyc();
    chk("R9 closing branch deferred", {63'd0, rec_we}, 64'd0);
    cyc();
    ev(1, 32'h314, 0); cyc();
    chk("R9 released by unrecorded fetch", {63'd0, rec_we}, 64'd1);
    chk("R9 released addr", {32'd0, rec_addr}, 64'h310);
    chk("R9 released stamp", {16'd0, rec_ts}, tcnt - 64'd1);
    cyc();
    chk("R9 fetch outside window dropped", {63'd0, rec_we}, 64'd0);

    // R6: halt mode
    rearm = 1; cyc();
    mode = 1;
    ev(1, 32'h400, 0); cyc();
    chk("R6 recorded before halt", {63'd0, rec_we}, 64'd1);
    cyc();
    halt_h = 1; ev(0, 32'h404, 0); cyc();
    chk("R6 halt cycle not recorded", {63'd0, rec_we}, 64'd0);
    chk("R6 halted raised", {63'd0, halted}, 64'd1);
    cyc();
    ev(0, 32'h408, 0); cyc();
    chk("R6 silent while halted", {63'd0, rec_we}, 64'd0);
    chk("R6 halted sticky", {63'd0, halted}, 64'd1);
    cyc();
    rearm = 1; cyc();
    chk("R6 rearm clears halted", {63'd0, halted}, 64'd0);
    ev(0, 32'h40c, 0); cyc();
    chk("R6 recording after rearm", {63'd0, rec_we}, 64'd1);
    chk("R10 narrow counter wrapped", {59'd0, s_ts}, (tcnt - 64'd1) & 64'h1f);
    chk("R10 wide stamp", {16'd0, rec_ts}, tcnt - 64'd1);
    cyc();

    // R11: off mode
    mode = 3;
    ev(0, 32'h500, 1); cyc();
    chk("R11 off mode records nothing", {63'd0, rec_we}, 64'd0);
    cyc();

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule